// File: doc/BRIEF.md
# Selective Cached/Uncached Load Steering Unit

This block sits between a core's load port and the memory hierarchy. It takes one load request at a time, and each request carries a class bit that says whether the access is expected to have locality.

Requests with locality are looked up in a small cache through a cache-side port. On a miss, the block fetches a full 64-byte line from memory, tells the cache to allocate that line, and then issues a prefetch for the following line. That prefetch is dropped if the same line was prefetched recently.

Requests without locality never touch the cache. They go straight to memory as a narrow 4-byte or 8-byte read, so that scattered per-element data costs neither cache capacity nor line bandwidth.

Every request gets exactly one response, returned in request order with its tag. Two byte counters record how much memory traffic each path generated. Either counter can be read through a small select/readback port.

Top module: `sel_load_path`

## Requirements
- R1: With `req_nolocal`=0 the request is first presented on the cache lookup port. With `req_nolocal`=1 the block issues no cache lookup and goes straight to memory.
- R2: An uncached request uses memory size code 0 (4 bytes) when `req_wide`=0 and code 1 (8 bytes) when `req_wide`=1. Its address is aligned down to that size.
- R3: An uncached request never pulses `cache_fill_valid` and never issues a prefetch (`mem_req_pf`=1).
- R4: A cache miss (`cache_rsp_hit`=0) issues one memory request with size code 2 (64-byte line) at the requested address aligned down to 8 bytes; that 8-byte word is the one returned. The block then pulses `cache_fill_valid` for one cycle with `cache_fill_line` = address bits [AW-1:6].
- R5: After a fill, the block issues a memory request with size code 2, `mem_req_pf`=1 and the base address of the next line. It skips this prefetch when that line is among the last PF_HIST (default 4) lines prefetched; a fifth newer prefetch evicts the oldest of them.
- R6: A response with `req_wide`=0 holds a 32-bit value zero-extended to 64 bits. On the cached path it is the half of the returned 8-byte word chosen by address bit 2 (1 = upper half). On the uncached path it is bits [31:0] of the memory reply, and the upper reply bits are ignored. A response with `req_wide`=1 holds the full 64-bit word.
- R7: Each accepted request produces exactly one `rsp_valid` pulse carrying its tag, in acceptance order. `req_ready` is low from acceptance until that pulse.
- R8: The cached byte counter grows by 64 for each line or prefetch request accepted by memory. The uncached counter grows by 4 or 8 per narrow request. `cnt_rdata` shows the cached counter when `cnt_sel`=0 and the uncached one when `cnt_sel`=1, one cycle after `cnt_sel` is applied.
- R9: After reset `req_ready` is 1, `rsp_valid`, `cache_req_valid` and `mem_req_valid` are 0, and both counters read 0.
- R10: A cache hit returns its response without any memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core load request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Byte address of the load |
| req_nolocal | input | 1 | 1 = no locality, bypass the cache |
| req_wide | input | 1 | 1 = 8-byte load, 0 = 4-byte load |
| req_tag | input | TW | Tag returned with the response |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_tag | output | TW | Tag of the response |
| rsp_data | output | 64 | Load data |
| cache_req_valid | output | 1 | Cache lookup request |
| cache_req_ready | input | 1 | Cache accepts the lookup |
| cache_req_addr | output | AW | Lookup address |
| cache_rsp_valid | input | 1 | Cache lookup result valid |
| cache_rsp_hit | input | 1 | Lookup hit |
| cache_rsp_data | input | 64 | 8-byte word holding the address on a hit |
| cache_fill_valid | output | 1 | Allocate the line just fetched |
| cache_fill_line | output | AW-6 | Line number to allocate |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Memory request address |
| mem_req_size | output | 2 | 0 = 4 B, 1 = 8 B, 2 = 64 B line |
| mem_req_pf | output | 1 | Prefetch request, no reply expected |
| mem_rsp_valid | input | 1 | Memory reply valid |
| mem_rsp_data | input | 64 | Memory reply data |
| cnt_sel | input | 1 | Counter select: 0 cached, 1 uncached |
| cnt_rdata | output | CNT_W | Selected byte counter |

## Verification
The bench puts junk in the upper half of narrow memory replies. A design that forwarded the whole reply instead of zero-extending bits [31:0] would return wrong data. It misses twice in one line to show that a recent prefetch suppresses a second one; a design without that filter would double the line traffic. It then misses in five distinct lines so that an old prefetch falls out of the history and is issued again; a filter that never forgets, or that is too short, would be caught here. Uncached loads of both widths at unaligned addresses are checked for the size code, the aligned address, and the absence of any cache lookup, fill or prefetch. A design that leaked them into the cache would show up in both the event counts and the byte counters.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    SZ_W4   = 2'd0,
    SZ_W8   = 2'd1,
    SZ_LINE = 2'd2
  } msize_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CREQ, ST_CWAIT, ST_MREQ, ST_MWAIT, ST_FILL, ST_PFREQ, ST_RESP
  } st_e;
endpackage

// File: rtl/slp_pf_filter.sv
module slp_pf_filter #(
  parameter int LN_W    = 26,
  parameter int PF_HIST = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LN_W-1:0] chk_line,
  input  logic            push,
  input  logic [LN_W-1:0] push_line,
  output logic            hit
);
  logic [LN_W-1:0]    hist_line [PF_HIST];
  logic [PF_HIST-1:0] hist_vld;
  logic [PF_HIST-1:0] match;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_vld <= '0;
    end else if (push) begin
      hist_vld <= {hist_vld[PF_HIST-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (push) hist_line[0] <= push_line;
  end

  for (genvar i = 1; i < PF_HIST; i++) begin : g_shift
    always_ff @(posedge clk) begin
      if (push) hist_line[i] <= hist_line[i-1];
    end
  end

  for (genvar i = 0; i < PF_HIST; i++) begin : g_cmp
    assign match[i] = hist_vld[i] && (hist_line[i] == chk_line);
  end

  assign hit = |match;
endmodule

// File: rtl/slp_byte_counters.sv
module slp_byte_counters
  import slp_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add,
  input  msize_e           size,
  input  logic             sel,
  output logic [CNT_W-1:0] rdata
);
  logic [CNT_W-1:0] cnt_cached;
  logic [CNT_W-1:0] cnt_unc;
  logic [CNT_W-1:0] nbytes;

  always_comb begin
    case (size)
      SZ_W4:   nbytes = CNT_W'(4);
      SZ_W8:   nbytes = CNT_W'(8);
      default: nbytes = CNT_W'(LINE_BYTES);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_cached <= '0;
      cnt_unc    <= '0;
      rdata      <= '0;
    end else begin
      if (add && size == SZ_LINE) cnt_cached <= cnt_cached + nbytes;
      if (add && size != SZ_LINE) cnt_unc    <= cnt_unc + nbytes;
      rdata <= sel ? cnt_unc : cnt_cached;
    end
  end
endmodule

// File: rtl/sel_load_path.sv
module sel_load_path
  import slp_pkg::*;
#(
  parameter int AW         = 32,
  parameter int TW         = 4,
  parameter int LINE_BYTES = 64,
  parameter int PF_HIST    = 4,
  parameter int CNT_W      = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [AW-1:0]                 req_addr,
  input  logic                          req_nolocal,
  input  logic                          req_wide,
  input  logic [TW-1:0]                 req_tag,
  output logic                          rsp_valid,
  output logic [TW-1:0]                 rsp_tag,
  output logic [63:0]                   rsp_data,
  output logic                          cache_req_valid,
  input  logic                          cache_req_ready,
  output logic [AW-1:0]                 cache_req_addr,
  input  logic                          cache_rsp_valid,
  input  logic                          cache_rsp_hit,
  input  logic [63:0]                   cache_rsp_data,
  output logic                          cache_fill_valid,
  output logic [AW-$clog2(LINE_BYTES)-1:0] cache_fill_line,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [AW-1:0]                 mem_req_addr,
  output logic [1:0]                    mem_req_size,
  output logic                          mem_req_pf,
  input  logic                          mem_rsp_valid,
  input  logic [63:0]                   mem_rsp_data,
  input  logic                          cnt_sel,
  output logic [CNT_W-1:0]              cnt_rdata
);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int LN_W  = AW - OFS_W;

  st_e             st;
  logic [AW-1:0]   r_addr;
  logic            r_unc;
  logic            r_wide;
  logic [TW-1:0]   r_tag;
  logic [63:0]     r_data;
  logic [LN_W-1:0] line_cur;
  logic [LN_W-1:0] line_nxt;
  logic            pf_hit;
  msize_e          size_q;
  logic            mem_fire;

  assign line_cur = r_addr[AW-1:OFS_W];
  assign line_nxt = line_cur + LN_W'(1);

  function automatic logic [63:0] pick(input logic [63:0] d, input logic hi, input logic wide);
    if (wide) return d;
    return {32'b0, hi ? d[63:32] : d[31:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      r_addr <= '0;
      r_unc  <= 1'b0;
      r_wide <= 1'b0;
      r_tag  <= '0;
      r_data <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          r_addr <= req_addr;
          r_unc  <= req_nolocal;
          r_wide <= req_wide;
          r_tag  <= req_tag;
          st     <= req_nolocal ? ST_MREQ : ST_CREQ;
        end
        ST_CREQ:  if (cache_req_ready) st <= ST_CWAIT;
        ST_CWAIT: if (cache_rsp_valid) begin
          if (cache_rsp_hit) begin
            r_data <= pick(cache_rsp_data, r_addr[2], r_wide);
            st     <= ST_RESP;
          end else begin
            st <= ST_MREQ;
          end
        end
        ST_MREQ:  if (mem_req_ready) st <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          if (r_unc) begin
            r_data <= r_wide ? mem_rsp_data : {32'b0, mem_rsp_data[31:0]};
            st     <= ST_RESP;
          end else begin
            r_data <= pick(mem_rsp_data, r_addr[2], r_wide);
            st     <= ST_FILL;
          end
        end
        ST_FILL:  st <= pf_hit ? ST_RESP : ST_PFREQ;
        ST_PFREQ: if (mem_req_ready) st <= ST_RESP;
        ST_RESP:  st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (st == ST_PFREQ || !r_unc) size_q = SZ_LINE;
    else if (r_wide)              size_q = SZ_W8;
    else                          size_q = SZ_W4;
  end

  always_comb begin
    if (st == ST_PFREQ)      mem_req_addr = {line_nxt, {OFS_W{1'b0}}};
    else if (size_q == SZ_W4) mem_req_addr = {r_addr[AW-1:2], 2'b00};
    else                      mem_req_addr = {r_addr[AW-1:3], 3'b000};
  end

  assign req_ready        = (st == ST_IDLE);
  assign rsp_valid        = (st == ST_RESP);
  assign rsp_tag          = r_tag;
  assign rsp_data         = r_data;
  assign cache_req_valid  = (st == ST_CREQ);
  assign cache_req_addr   = r_addr;
  assign cache_fill_valid = (st == ST_FILL);
  assign cache_fill_line  = line_cur;
  assign mem_req_valid    = (st == ST_MREQ) || (st == ST_PFREQ);
  assign mem_req_pf       = (st == ST_PFREQ);
  assign mem_req_size     = size_q;
  assign mem_fire         = mem_req_valid && mem_req_ready;

  slp_pf_filter #(.LN_W(LN_W), .PF_HIST(PF_HIST)) u_filt (
    .clk       (clk),
    .rst       (rst),
    .chk_line  (line_nxt),
    .push      (mem_fire && st == ST_PFREQ),
    .push_line (line_nxt),
    .hit       (pf_hit)
  );

  slp_byte_counters #(.CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .add   (mem_fire),
    .size  (size_q),
    .sel   (cnt_sel),
    .rdata (cnt_rdata)
  );
endmodule

// File: rtl/sel_load_path_chk.sv
module sel_load_path_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_nolocal,
  input logic          rsp_valid,
  input logic          cache_req_valid,
  input logic          cache_fill_valid,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic [1:0]    mem_req_size,
  input logic          mem_req_pf
);
  logic [1:0] inflight;
  logic       cur_unc;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight <= '0;
      cur_unc  <= 1'b0;
    end else begin
      if (req_valid && req_ready) cur_unc <= req_nolocal;
      case ({req_valid && req_ready, rsp_valid})
        2'b10:   inflight <= inflight + 2'd1;
        2'b01:   inflight <= inflight - 2'd1;
        default: inflight <= inflight;
      endcase
    end
  end

  AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (rst) inflight <= 2'd1); // R7
  AST_RSP_MATCHED:  assert property (@(posedge clk) disable iff (rst) rsp_valid |-> inflight == 2'd1); // R7
  AST_UNC_NO_CACHE: assert property (@(posedge clk) disable iff (rst)
                      cur_unc |-> !cache_req_valid && !cache_fill_valid && !mem_req_pf); // R3
  AST_SIZE_ALIGN_4: assert property (@(posedge clk) disable iff (rst)
                      mem_req_valid && mem_req_size == 2'd0 |-> mem_req_addr[1:0] == 2'b00); // R2
  AST_SIZE_ALIGN_8: assert property (@(posedge clk) disable iff (rst)
                      mem_req_valid && mem_req_size != 2'd0 |-> mem_req_addr[2:0] == 3'b000); // R4
  AST_PF_IS_LINE:   assert property (@(posedge clk) disable iff (rst)
                      mem_req_valid && mem_req_pf |-> mem_req_size == 2'd2 && mem_req_addr[5:0] == 6'd0); // R5
  AST_MEM_HOLD:     assert property (@(posedge clk) disable iff (rst)
                      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R4
endmodule

bind sel_load_path sel_load_path_chk #(.AW(AW)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .req_nolocal      (req_nolocal),
  .rsp_valid        (rsp_valid),
  .cache_req_valid  (cache_req_valid),
  .cache_fill_valid (cache_fill_valid),
  .mem_req_valid    (mem_req_valid),
  .mem_req_ready    (mem_req_ready),
  .mem_req_addr     (mem_req_addr),
  .mem_req_size     (mem_req_size),
  .mem_req_pf       (mem_req_pf)
);

// File: tb/sel_load_path_test.sv
module sel_load_path_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_ready, req_nolocal = 1'b0, req_wide = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_tag = '0;
  logic rsp_valid;
  logic [TW-1:0] rsp_tag;
  logic [63:0] rsp_data;
  logic cache_req_valid, cache_req_ready = 1'b1;
  logic [AW-1:0] cache_req_addr;
  logic cache_rsp_valid = 1'b0, cache_rsp_hit = 1'b0;
  logic [63:0] cache_rsp_data = '0;
  logic cache_fill_valid;
  logic [AW-7:0] cache_fill_line;
  logic mem_req_valid, mem_req_ready = 1'b1, mem_req_pf;
  logic [AW-1:0] mem_req_addr;
  logic [1:0] mem_req_size;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic cnt_sel = 1'b0;
  logic [31:0] cnt_rdata;

  sel_load_path uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [TW+63:0] exp_q[$];
  logic hit_mode = 1'b0;
  int n_creq = 0, n_mem = 0, n_pf = 0, n_fill = 0;
  logic [AW-1:0] last_mem_addr = '0, last_pf_addr = '0;
  logic [1:0] last_mem_size = '0;
  logic [AW-7:0] last_fill = '0;
  logic c_pend = 0, m_pend = 0;
  logic [AW-1:0] c_addr = '0, m_addr = '0;
  logic [1:0] m_size = '0;
  logic [TW-1:0] tag_n = '0;

  function automatic logic [31:0] w32(input logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction
  function automatic logic [63:0] w64(input logic [AW-1:0] a);
    return {w32(a + 32'd4), w32(a)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cache model, memory model and response monitor
  always @(negedge clk) begin
    cache_rsp_valid = c_pend;
    if (c_pend) begin
      cache_rsp_hit  = hit_mode;
      cache_rsp_data = w64(c_addr & ~32'd7);
    end
    c_pend = cache_req_valid;
    c_addr = cache_req_addr;
    if (cache_req_valid) n_creq++;
    mem_rsp_valid = m_pend;
    if (m_pend) mem_rsp_data = (m_size == 2'd0) ? {32'hDEADBEEF, w32(m_addr)} : w64(m_addr);
    m_pend = mem_req_valid && !mem_req_pf;
    m_addr = mem_req_addr;
    m_size = mem_req_size;
    if (mem_req_valid && mem_req_pf) begin n_pf++; last_pf_addr = mem_req_addr; end
    else if (mem_req_valid) begin n_mem++; last_mem_addr = mem_req_addr; last_mem_size = mem_req_size; end
    if (cache_fill_valid) begin n_fill++; last_fill = cache_fill_line; end
    if (rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected response", {60'b0, rsp_tag}, 64'd0);
      else begin
        logic [TW+63:0] e;
        e = exp_q.pop_front();
        chk(rsp_tag == e[TW+63:64], "R7 tag", {60'b0, rsp_tag}, {60'b0, e[TW+63:64]});
        chk(rsp_data == e[63:0], "R6 data", rsp_data, e[63:0]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  int d_creq, d_mem, d_pf, d_fill;

  task automatic send(input logic [AW-1:0] a, input logic unc, input logic wide, input logic hit);
    int s_creq, s_mem, s_pf, s_fill;
    logic [63:0] e;
    s_creq = n_creq; s_mem = n_mem; s_pf = n_pf; s_fill = n_fill;
    e = wide ? w64(a & ~32'd7) : {32'b0, w32(a & ~32'd3)};
    tag_n = tag_n + 1'b1;
    exp_q.push_back({tag_n, e});
    @(negedge clk);
    hit_mode = hit; req_valid = 1; req_addr = a; req_nolocal = unc; req_wide = wide; req_tag = tag_n;
    @(negedge clk);
    req_valid = 0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    d_creq = n_creq - s_creq; d_mem = n_mem - s_mem; d_pf = n_pf - s_pf; d_fill = n_fill - s_fill;
  endtask

  task automatic read_cnt(input logic s, input logic [31:0] exp, input string req);
    @(negedge clk); cnt_sel = s;
    @(negedge clk);
    chk(cnt_rdata == exp, req, {32'b0, cnt_rdata}, {32'b0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 req_ready", {63'b0, req_ready}, 64'd1);
    chk(!rsp_valid && !mem_req_valid && !cache_req_valid, "R9 valids low",
        {61'b0, rsp_valid, mem_req_valid, cache_req_valid}, 64'd0);
    read_cnt(0, 32'd0, "R9 cached counter");
    read_cnt(1, 32'd0, "R9 uncached counter");

    // R1 R10: cached hit, narrow, upper half
    send(32'h1004, 0, 0, 1);
    chk(d_creq == 1, "R1 cache lookup on hit", 64'(d_creq), 64'd1);
    chk(d_mem == 0 && d_pf == 0, "R10 no memory traffic on hit", 64'(d_mem + d_pf), 64'd0);

    // R4 R5: miss, wide
    send(32'h2013, 0, 1, 0);
    chk(d_mem == 1 && last_mem_addr == 32'h2010 && last_mem_size == 2'd2, "R4 line request",
        {30'b0, last_mem_size, last_mem_addr}, {30'b0, 2'd2, 32'h2010});
    chk(d_fill == 1 && last_fill == 26'h80, "R4 fill line", 64'(last_fill), 64'h80);
    chk(d_pf == 1 && last_pf_addr == 32'h2040, "R5 next-line prefetch", 64'(last_pf_addr), 64'h2040);

    // R5: second miss in same line, prefetch suppressed; R6 lower half narrow
    send(32'h2038, 0, 0, 0);
    chk(d_fill == 1 && d_pf == 0, "R5 recent prefetch suppressed", 64'(d_pf), 64'd0);

    // R2 R3 R6: uncached narrow, junk upper half ignored
    send(32'h3007, 1, 0, 1);
    chk(d_creq == 0, "R1 no cache lookup for uncached", 64'(d_creq), 64'd0);
    chk(last_mem_addr == 32'h3004 && last_mem_size == 2'd0, "R2 narrow size/align",
        {30'b0, last_mem_size, last_mem_addr}, {30'b0, 2'd0, 32'h3004});
    chk(d_fill == 0 && d_pf == 0, "R3 no fill or prefetch", 64'(d_fill + d_pf), 64'd0);

    // R2 R3: uncached wide
    send(32'h300D, 1, 1, 1);
    chk(last_mem_addr == 32'h3008 && last_mem_size == 2'd1, "R2 wide size/align",
        {30'b0, last_mem_size, last_mem_addr}, {30'b0, 2'd1, 32'h3008});
    chk(d_creq == 0 && d_fill == 0 && d_pf == 0, "R3 wide no cache use", 64'(d_creq + d_fill + d_pf), 64'd0);

    read_cnt(0, 32'd192, "R8 cached bytes");
    read_cnt(1, 32'd12, "R8 uncached bytes");

    // R5 history eviction
    for (int i = 1; i <= 4; i++) begin
      send(32'(i) << 14, 0, 1, 0);
      chk(d_pf == 1 && last_pf_addr == (32'(i) << 14) + 32'd64, "R5 prefetch in new line",
          64'(last_pf_addr), 64'((32'(i) << 14) + 32'd64));
    end
    send(32'h1_0008, 0, 0, 0);
    chk(d_pf == 0, "R5 still in history", 64'(d_pf), 64'd0);
    send(32'h2000, 0, 0, 0);
    chk(d_pf == 1 && last_pf_addr == 32'h2040, "R5 evicted line prefetched again", 64'(last_pf_addr), 64'h2040);

    read_cnt(0, 32'd896, "R8 cached bytes after eviction");
    read_cnt(1, 32'd12, "R8 uncached unchanged");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule